// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns 8-bit characters into asynchronous serial frames on a single output line. Each frame is a low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity. Between frames the line rests high. The bit period is derived from the system clock by a programmable divider. An 8-bit divisor value N and a speed-select bit set the period to K·(N+1) clock cycles, where K is 16 or 64.

Software writes a character with a one-cycle strobe into a holding register. A separate shift register sends the frame. If the shifter is idle, the character moves across on the next clock and the holding register is free again. While a frame is in flight, one more character can wait in the holding register. That character starts in the bit period right after the current stop bit, so a stream of characters goes out with no idle gaps. A flag tells software when the holding register can take a new character. A transmit-enable input gates the whole block.

Top module: `async_tx_core`

## Requirements
- R1: Every bit of a frame, including start and stop, lasts exactly K·(N+1) clock cycles. N is the unsigned value on `div_val`.
- R2: K is 16 while `fast_sel` is 1 and 64 while `fast_sel` is 0.
- R3: A write strobe sampled while `tx_en` is 1 and `hold_empty` is 1 captures `wr_data`, and `hold_empty` reads 0 in the following cycle.
- R4: When the shifter is idle, a captured character moves to the shifter on the next clock. In that cycle `hold_empty` returns to 1 and `ser_out` goes low for the start bit.
- R5: The frame on `ser_out` is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit. While no frame is being sent, `ser_out` is 1.
- R6: If a character is waiting when a stop bit ends, its start bit begins in the very next cycle, with no idle time.
- R7: While a character waits behind an active frame, `hold_empty` stays 0. It becomes 1 in the cycle in which the next frame's start bit appears.
- R8: A write strobe while the holding register is full is ignored, and the waiting character is sent unchanged.
- R9: `div_val` and `fast_sel` are sampled only when a frame starts. A change during a frame does not alter that frame's bit length, and it applies from the next frame.
- R10: While `tx_en` is 0, `ser_out` is 1 from the next cycle, the holding register is cleared so `hold_empty` reads 1, writes are ignored, and any frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| wr_stb | input | 1 | One-cycle write strobe for a character |
| wr_data | input | 8 | Character to send |
| div_val | input | 8 | Divisor value N |
| fast_sel | input | 1 | Speed select: 1 gives K=16, 0 gives K=64 |
| hold_empty | output | 1 | Holding register can accept a character |
| ser_out | output | 1 | Serial output line |

## Verification
The hardest situation to reach is a write that arrives while a second character is already waiting behind a frame in flight. It needs an exact sequence: first a write to an idle transmitter, then a second write after the handoff, then a third write before the first stop bit ends. The bench drives this sequence with writes scheduled at chosen cycle offsets inside a running frame. It checks every cycle of the two frames that follow against waveforms computed from the period formula. It then watches the line for two quiet bit periods to confirm that the third character never went out. The same in-frame timing is used to change the divisor in the middle of a bit and to drop the enable in the middle of a frame.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } shift_state_e;

endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud #(
    parameter int DIV_W  = 8,
    parameter int K_FAST = 16,
    parameter int K_SLOW = 64,
    parameter int PER_W  = $clog2(K_SLOW) + DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [DIV_W-1:0] div_val,
    input  logic             fast_sel,
    output logic             tick,
    output logic [PER_W-1:0] limit
);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] lim;
    } baud_st_t;

    baud_st_t st_d, st_q;
    logic [PER_W-1:0] k_sel;
    logic [PER_W-1:0] per_last;

    always_comb begin
        k_sel    = fast_sel ? PER_W'(K_FAST) : PER_W'(K_SLOW);
        per_last = k_sel * (PER_W'(div_val) + PER_W'(1)) - PER_W'(1);
        st_d     = st_q;
        if (load) begin
            st_d.cnt = '0;
            st_d.lim = per_last;
        end else if (run) begin
            if (st_q.cnt == st_q.lim) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + PER_W'(1);
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick  = run && (st_q.cnt == st_q.lim);
    assign limit = st_q.lim;

endmodule

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.full = 1'b0;
            st_d.data = '0;
        end else if (take) begin
            st_d.full = 1'b0;
        end else if (wr && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign data = st_q.data;

endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
    import async_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 2,
    parameter int IDX_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              busy,
    output logic              line
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        shift_state_e       state;
        logic [FRAME_W-1:0] frame;
        logic [IDX_W-1:0]   idx;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      frame_end;

    always_comb begin
        frame_end = (st_q.state == SH_BUSY) && tick && (st_q.idx == LAST_IDX);
        take      = en && hold_full && ((st_q.state == SH_IDLE) || frame_end);
        st_d      = st_q;
        if (!en) begin
            st_d.state = SH_IDLE;
            st_d.frame = '1;
            st_d.idx   = '0;
        end else if (take) begin
            st_d.state = SH_BUSY;
            st_d.frame = {1'b1, hold_data, 1'b0};
            st_d.idx   = '0;
        end else if (frame_end) begin
            st_d.state = SH_IDLE;
            st_d.frame = '1;
            st_d.idx   = '0;
        end else if ((st_q.state == SH_BUSY) && tick) begin
            st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
            st_d.idx   = st_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= SH_IDLE;
            st_q.frame <= '1;
            st_q.idx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.state == SH_BUSY);
    assign line = st_q.frame[0];

endmodule

// File: rtl/async_tx_core.sv
module async_tx_core #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int K_FAST = 16,
    parameter int K_SLOW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              fast_sel,
    output logic              hold_empty,
    output logic              ser_out
);

    localparam int PER_W = $clog2(K_SLOW) + DIV_W;

    logic              take_w;
    logic              busy_w;
    logic              tick_w;
    logic              hold_full_w;
    logic [DATA_W-1:0] hold_data_w;
    logic [PER_W-1:0]  limit_w;

    async_tx_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tx_en),
        .wr    (wr_stb),
        .wdata (wr_data),
        .take  (take_w),
        .full  (hold_full_w),
        .data  (hold_data_w)
    );

    async_tx_baud #(
        .DIV_W  (DIV_W),
        .K_FAST (K_FAST),
        .K_SLOW (K_SLOW),
        .PER_W  (PER_W)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_w),
        .load     (take_w),
        .div_val  (div_val),
        .fast_sel (fast_sel),
        .tick     (tick_w),
        .limit    (limit_w)
    );

    async_tx_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .tick      (tick_w),
        .hold_full (hold_full_w),
        .hold_data (hold_data_w),
        .take      (take_w),
        .busy      (busy_w),
        .line      (ser_out)
    );

    assign hold_empty = !hold_full_w;

endmodule

// File: rtl/async_tx_core_chk.sv
module async_tx_core_chk #(
    parameter int DATA_W = 8,
    parameter int PER_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              wr_stb,
    input logic              ser_out,
    input logic              hold_empty,
    input logic              take,
    input logic              busy,
    input logic              hold_full,
    input logic [DATA_W-1:0] hold_data,
    input logic [PER_W-1:0]  limit
);

    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (ser_out && hold_empty));

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_stb && hold_empty) |=> !hold_empty);

    p_hold_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && hold_full && !take) |=> $stable(hold_data));

    p_start_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ser_out);

    p_take_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> hold_empty);

    p_period_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !take) |=> $stable(limit));

endmodule

bind async_tx_core async_tx_core_chk #(
    .DATA_W (DATA_W),
    .PER_W  (PER_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .wr_stb     (wr_stb),
    .ser_out    (ser_out),
    .hold_empty (hold_empty),
    .take       (take_w),
    .busy       (busy_w),
    .hold_full  (hold_full_w),
    .hold_data  (hold_data_w),
    .limit      (limit_w)
);

// File: tb/test_async_tx_core.sv
module test_async_tx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] div_val = '0;
    logic       fast_sel = 1'b1;
    logic       hold_empty;
    logic       ser_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    async_tx_core i_async_tx_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .div_val    (div_val),
        .fast_sel   (fast_sel),
        .hold_empty (hold_empty),
        .ser_out    (ser_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int period(input int f, input int n);
        return (f != 0 ? 16 : 64) * (n + 1);
    endfunction

    function automatic logic bit_of(input logic [7:0] d, input int b);
        if (b == 0) return 1'b0;
        if (b == 9) return 1'b1;
        return d[b-1];
    endfunction

    // Drive one write strobe; returns at the falling edge after the capturing edge.
    task automatic put(input logic [7:0] d);
        wr_stb  = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // Starts at the falling edge where the start bit first shows; ends on the
    // last sample of the stop bit.
    task automatic expect_frame(input logic [7:0] d, input int p, input string req);
        for (int b = 0; b < 10; b++) begin
            int bad = 0;
            int seen = 0;
            for (int k = 0; k < p; k++) begin
                if (b > 0 || k > 0) @(negedge clk);
                if (ser_out !== bit_of(d, b)) begin
                    bad++;
                    seen = ser_out;
                end
            end
            chk(bad == 0, req, bad == 0 ? int'(bit_of(d, b)) : seen, int'(bit_of(d, b)));
        end
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        int bad = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (ser_out !== 1'b1 || hold_empty !== 1'b1) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ser_out === 1'b1, "R5 reset idle line", ser_out, 1);
        chk(hold_empty === 1'b1, "R10 reset empty flag", hold_empty, 1);
        rst_n = 1'b1;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5: sweep of speed, divisor and data patterns
        for (int f = 0; f < 2; f++) begin
            for (int n = 0; n < 4; n++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [7:0] d;
                    d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(8'h56 + n * 29 + f * 113);
                    fast_sel = f[0];
                    div_val  = 8'(n);
                    @(negedge clk);
                    put(d);
                    chk(hold_empty === 1'b0, "R3 flag after write", hold_empty, 0);
                    @(negedge clk);
                    chk(ser_out === 1'b0 && hold_empty === 1'b1, "R4 handoff",
                        {ser_out, hold_empty}, 1);
                    expect_frame(d, period(f, n), "R1 R2 R5 frame");
                    @(negedge clk);
                    chk(ser_out === 1'b1, "R5 idle after stop", ser_out, 1);
                end
            end
        end

        // R6 R7 R8: queued character, extra write ignored, no gap
        fast_sel = 1'b1;
        div_val  = 8'd1;
        @(negedge clk);
        put(8'hA5);
        @(negedge clk);
        fork
            expect_frame(8'hA5, 32, "R5 first of pair");
            begin
                repeat (3) @(negedge clk);
                put(8'h3C);
                chk(hold_empty === 1'b0, "R7 waiting flag", hold_empty, 0);
                repeat (40) @(negedge clk);
                put(8'hC3);
                repeat (200) @(negedge clk);
                chk(hold_empty === 1'b0, "R7 flag held to frame end", hold_empty, 0);
            end
        join
        @(negedge clk);
        chk(hold_empty === 1'b1, "R7 flag at next start", hold_empty, 1);
        expect_frame(8'h3C, 32, "R6 R8 back-to-back frame");
        expect_quiet(64, "R8 ignored write not sent");

        // R9: divisor change mid-frame applies only to the next frame
        put(8'h96);
        @(negedge clk);
        fork
            expect_frame(8'h96, 32, "R9 old period kept");
            begin
                repeat (50) @(negedge clk);
                div_val  = 8'd3;
                fast_sel = 1'b0;
            end
        join
        @(negedge clk);
        put(8'h69);
        @(negedge clk);
        expect_frame(8'h69, 256, "R9 new period used");
        @(negedge clk);

        // R10: disable behaviour
        fast_sel = 1'b1;
        div_val  = 8'd0;
        tx_en    = 1'b0;
        @(negedge clk);
        put(8'h00);
        chk(hold_empty === 1'b1, "R10 write ignored when disabled", hold_empty, 1);
        expect_quiet(40, "R10 line idle when disabled");
        tx_en = 1'b1;
        @(negedge clk);
        put(8'h00);
        @(negedge clk);
        repeat (16 * 3) @(negedge clk);
        chk(ser_out === 1'b0, "R10 frame running before abort", ser_out, 0);
        put(8'h00);
        chk(hold_empty === 1'b0, "R10 character queued", hold_empty, 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk(ser_out === 1'b1 && hold_empty === 1'b1, "R10 abort clears",
            {ser_out, hold_empty}, 3);
        tx_en = 1'b1;
        expect_quiet(48, "R10 queued character dropped");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule